// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer (Single Channel)

This block holds the digital side of a 10-bit successive-approximation analog-to-digital converter that selects one of eight analog inputs. Software controls it through a small register bus. A control/status register holds a channel field, a mode bit, an interrupt enable, a run bit and a completion flag. A conversion starts when software writes the run bit to 1 or when a rising edge arrives on an external trigger pin. The block then drives a trial code to the DAC. Each cycle it resolves one bit from the comparator answer, starting with the MSB. When the search ends it stores the result in one of four result registers.

When the search finishes, the run bit drops and the completion flag rises. An interrupt level is raised while both the flag and the enable are set. Software must read the status register while the flag is set, and only then does a write of 0 clear the flag. Writing 0 to the run bit during a search abandons that search. No result register changes and the flag stays as it was.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the status register (address 0) reads 0, all four result registers (addresses 1 to 4) read 0, `dac_code` is 0 and `irq` is 0.
- R2: A status write with bit 5 (run) set starts a conversion on the next clock. Bit 5 reads 1 for exactly ten cycles. In the eleventh cycle bit 5 reads 0 and bit 6 (done) reads 1.
- R3: The first trial code on `dac_code` is the MSB alone (0x200). Each following cycle keeps the trial bit if `cmp_hi` was 1 and clears it otherwise, then sets the next lower bit. The stored result equals the analog level, including 0 and 0x3FF.
- R4: The result goes to the result register selected by the two low channel bits (bits 1:0 of the status register): channel c goes to address 1 + (c mod 4). Channels 1 and 5 both go to address 2. The other result registers keep their values.
- R5: `irq` is high exactly while done (bit 6) and interrupt enable (bit 4) are both 1.
- R6: Done is cleared only by a status write with bit 6 = 0 that follows a status read made while done was 1. A write of 0 without that read leaves done at 1. Software cannot set done.
- R7: A status write with bit 5 = 0 during a conversion aborts it on the next clock. `dac_code` returns to 0, done is not set, and no result register changes.
- R8: A single status write may change the channel (bits 2:0) and set run in the same write. That conversion uses the newly written channel.
- R9: A rising edge on `ext_trig` starts a conversion on the current channel after a two-flop synchroniser.
- R10: A rising edge on `ext_trig` while a conversion runs is ignored. No second conversion follows.
- R11: The channel (bits 2:0), mode (bit 3) and interrupt enable (bit 4) read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (needed for the flag-clear rule) |
| bus_addr | input | 3 | Register address: 0 status, 1 to 4 results |
| bus_wdata | input | 7 | Write data for the status register |
| bus_rdata | output | 10 | Combinational read data for `bus_addr` |
| ext_trig | input | 1 | Asynchronous conversion trigger, rising edge |
| cmp_hi | input | 1 | Comparator: 1 when the analog level is at least `dac_code` |
| dac_code | output | 10 | Trial code to the DAC, 0 while idle |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with its defaults: 10-bit resolution, four result registers and a two-stage trigger synchroniser. With four registers, channels 1 and 5, and channels 0 and 4, land in the same register, so the aliasing rule can be tested directly. With 10 bits, the all-ones and all-zeros levels take only ten cycles each, so both extremes of the search are exercised alongside mixed bit patterns. The bench models the comparator from an analog level and the live DAC code. It checks the cycle the run bit drops, the flag-clear handshake, abort, and triggers arriving both idle and busy.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  // status register field positions
  localparam int CsrW     = 7;
  localparam int ChLo     = 0;
  localparam int ChHi     = 2;
  localparam int BitScan  = 3;
  localparam int BitIe    = 4;
  localparam int BitRun   = 5;
  localparam int BitDone  = 6;
  // address map
  localparam int AddrCsr   = 0;
  localparam int AddrData0 = 1;
endpackage

// File: rtl/sar_trig_sync.sv
module sar_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], trig_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                abort,
  input  logic                cmp_hi,
  output logic                busy,
  output logic                fin,
  output logic [RES_BITS-1:0] result,
  output logic [RES_BITS-1:0] dac_code
);
  localparam int IDX_W = $clog2(RES_BITS);

  logic                busy_q, busy_d;
  logic [RES_BITS-1:0] code_q, code_d, keep;
  logic [IDX_W-1:0]    idx_q, idx_d, idx_m1;
  logic                en;

  assign idx_m1 = idx_q - IDX_W'(1);

  always_comb begin
    busy_d = busy_q;
    code_d = code_q;
    idx_d  = idx_q;
    fin    = 1'b0;
    keep   = code_q;
    if (!cmp_hi) keep[idx_q] = 1'b0;
    if (busy_q) begin
      if (abort) begin
        busy_d = 1'b0;
        code_d = '0;
        idx_d  = '0;
      end else if (idx_q == '0) begin
        fin    = 1'b1;
        busy_d = 1'b0;
        code_d = '0;
      end else begin
        code_d         = keep;
        code_d[idx_m1] = 1'b1;
        idx_d          = idx_m1;
      end
    end else if (go) begin
      busy_d                 = 1'b1;
      code_d                 = '0;
      code_d[RES_BITS-1]     = 1'b1;
      idx_d                  = IDX_W'(RES_BITS - 1);
    end
  end

  assign en = busy_q | go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      code_q <= '0;
      idx_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      code_q <= code_d;
      idx_q  <= idx_d;
    end
  end

  assign busy     = busy_q;
  assign result   = keep;
  assign dac_code = code_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int NUM_DREG    = 4,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CsrW-1:0]     bus_wdata,
  output logic [RES_BITS-1:0] bus_rdata,
  input  logic                ext_trig,
  input  logic                cmp_hi,
  output logic [RES_BITS-1:0] dac_code,
  output logic                irq
);
  localparam int DIDX_W = $clog2(NUM_DREG);
  localparam int CH_W   = ChHi - ChLo + 1;

  // reset: asserted asynchronously, released after two clocks
  logic rst_s1_q, rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_int, rst_s1_q} <= 2'b00;
    else        {rst_n_int, rst_s1_q} <= {rst_s1_q, 1'b1};
  end

  logic csr_wr, csr_rd, sw_go, trig_rise, go_idle, abort, busy, fin;
  logic [RES_BITS-1:0] result;

  assign csr_wr  = bus_we && (bus_addr == ADDR_W'(AddrCsr));
  assign csr_rd  = bus_re && (bus_addr == ADDR_W'(AddrCsr));
  assign sw_go   = csr_wr && bus_wdata[BitRun];
  assign go_idle = (sw_go || trig_rise) && !busy;
  assign abort   = csr_wr && !bus_wdata[BitRun] && busy;

  sar_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .trig_in (ext_trig),
    .rise    (trig_rise)
  );

  sar_search #(.RES_BITS(RES_BITS)) u_search (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .go       (go_idle),
    .abort    (abort),
    .cmp_hi   (cmp_hi),
    .busy     (busy),
    .fin      (fin),
    .result   (result),
    .dac_code (dac_code)
  );

  // configuration fields
  logic [CH_W-1:0]   ch_q, ch_d;
  logic              scan_q, scan_d, ie_q, ie_d;
  logic [DIDX_W-1:0] tgt_q, tgt_d;
  logic              done_q, done_d, armed_q, armed_d;

  always_comb begin
    ch_d   = bus_wdata[ChHi:ChLo];
    scan_d = bus_wdata[BitScan];
    ie_d   = bus_wdata[BitIe];
    tgt_d  = csr_wr ? bus_wdata[ChLo +: DIDX_W] : ch_q[DIDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ch_q   <= '0;
      scan_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (csr_wr) begin
      ch_q   <= ch_d;
      scan_q <= scan_d;
      ie_q   <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   tgt_q <= '0;
    else if (go_idle) tgt_q <= tgt_d;
  end

  // completion flag with read-then-write-zero clear
  always_comb begin
    done_d  = done_q;
    armed_d = armed_q;
    if (csr_rd && done_q) armed_d = 1'b1;
    if (csr_wr && !bus_wdata[BitDone] && armed_q) begin
      done_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (fin) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      done_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      armed_q <= armed_d;
    end
  end

  // result registers
  logic [NUM_DREG-1:0] dreg_en;
  logic [RES_BITS-1:0] dreg_q [NUM_DREG];

  for (genvar g = 0; g < NUM_DREG; g++) begin : g_den
    assign dreg_en[g] = fin && (tgt_q == DIDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      for (int i = 0; i < NUM_DREG; i++) dreg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_DREG; i++)
        if (dreg_en[i]) dreg_q[i] <= result;
    end
  end

  // read mux
  logic [CsrW-1:0] csr_view;
  always_comb begin
    csr_view              = '0;
    csr_view[ChHi:ChLo]   = ch_q;
    csr_view[BitScan]     = scan_q;
    csr_view[BitIe]       = ie_q;
    csr_view[BitRun]      = busy;
    csr_view[BitDone]     = done_q;
    bus_rdata             = '0;
    if (bus_addr == ADDR_W'(AddrCsr)) bus_rdata = RES_BITS'(csr_view);
    for (int i = 0; i < NUM_DREG; i++)
      if (bus_addr == ADDR_W'(AddrData0 + i)) bus_rdata = dreg_q[i];
  end

  assign irq = done_q & ie_q;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst_n_int,
  input logic                busy,
  input logic                go_idle,
  input logic                fin,
  input logic                abort,
  input logic                csr_wr,
  input logic                done_q,
  input logic                ie_q,
  input logic                irq,
  input logic [RES_BITS-1:0] dac_code
);
  localparam logic [RES_BITS-1:0] MsbOnly = {1'b1, {(RES_BITS-1){1'b0}}};

  p_first_trial_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    go_idle |=> (busy && dac_code == MsbOnly));

  p_fin_sets_done_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    fin |=> (done_q && !busy));

  p_irq_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (fin && ie_q && !csr_wr) |=> irq);

  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    abort |=> (!busy && dac_code == '0));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_q && !csr_wr) |=> done_q);

  p_idle_dac_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy |-> (dac_code == '0 && !fin));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .busy      (busy),
  .go_idle   (go_idle),
  .fin       (fin),
  .abort     (abort),
  .csr_wr    (csr_wr),
  .done_q    (done_q),
  .ie_q      (ie_q),
  .irq       (irq),
  .dac_code  (dac_code)
);

// File: tb/sar_adc_ctrl_test.sv
`timescale 1ns/1ps
module sar_adc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [6:0] bus_wdata = '0;
  logic [9:0] bus_rdata;
  logic       ext_trig = 1'b0;
  logic       cmp_hi;
  logic [9:0] dac_code;
  logic       irq;
  logic [9:0] ain = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign cmp_hi = (ain >= dac_code);

  sar_adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_trig(ext_trig), .cmp_hi(cmp_hi), .dac_code(dac_code), .irq(irq)
  );

  typedef struct { logic [9:0] v; string tag; } exp_t;
  exp_t       sb_q[$];
  logic [9:0] exp_d [4];

  function automatic logic [9:0] csr_val(input logic [2:0] ch, input logic sc,
      input logic ie, input logic run, input logic dn);
    return {3'b000, dn, run, ie, sc, ch};
  endfunction

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [2:0] ch, input logic sc, input logic ie,
      input logic run, input logic dn);
    bus_addr  = 3'd0;
    bus_wdata = {dn, run, ie, sc, ch};
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd_csr(output logic [9:0] v);
    bus_addr = 3'd0;
    bus_re   = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_re   = 1'b0;
  endtask

  // driver: push expected, then issue the read the monitor compares
  task automatic sb_read_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      sb_q.push_back('{exp_d[i], tag});
      bus_addr = 3'(i + 1);
      bus_re   = 1'b1;
      @(negedge clk);
      bus_re   = 1'b0;
    end
  endtask

  // monitor: snoops result-register reads
  always @(negedge clk) begin
    #2;
    if (bus_re && bus_addr >= 3'd1 && bus_addr <= 3'd4) begin
      if (sb_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, bus_rdata, e.v);
      end
    end
  end

  task automatic convert(input logic [2:0] ch, input logic ie, input logic [9:0] lvl);
    ain = lvl;
    csr_write(ch, 1'b0, ie, 1'b1, 1'b0);
    repeat (11) @(negedge clk);
    exp_d[ch[1:0]] = lvl;
  endtask

  task automatic clear_done(input logic [2:0] ch, input logic ie);
    logic [9:0] v;
    rd_csr(v);
    csr_write(ch, 1'b0, ie, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] v;
    for (int i = 0; i < 4; i++) exp_d[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_csr(v);
    chk("R1 status after reset", v, 10'h000);
    chk("R1 dac_code after reset", dac_code, 10'h000);
    chk("R1 irq after reset", {9'b0, irq}, 10'h000);
    sb_read_all("R1 result regs after reset");

    // R11 field readback
    csr_write(3'd6, 1'b1, 1'b1, 1'b0, 1'b0);
    rd_csr(v);
    chk("R11 fields readback", v, csr_val(3'd6, 1'b1, 1'b1, 1'b0, 1'b0));

    // R2 / R3 timing of one conversion on channel 1
    ain = 10'h2A5;
    csr_write(3'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3 first trial MSB", dac_code, 10'h200);
    rd_csr(v);
    chk("R2 run bit set while converting", v, csr_val(3'd1, 1'b0, 1'b1, 1'b1, 1'b0));
    chk("R3 second trial keeps MSB", dac_code, 10'h300);
    repeat (8) @(negedge clk);
    chk("R5 irq low before done", {9'b0, irq}, 10'h000);
    rd_csr(v);
    chk("R2 run bit in tenth cycle", v, csr_val(3'd1, 1'b0, 1'b1, 1'b1, 1'b0));
    rd_csr(v);
    chk("R2 done in eleventh cycle", v, csr_val(3'd1, 1'b0, 1'b1, 1'b0, 1'b1));
    chk("R5 irq with done and enable", {9'b0, irq}, 10'h001);
    exp_d[1] = 10'h2A5;
    sb_read_all("R4 R3 result channel 1");

    // R6 proper clear (the read above armed it)
    csr_write(3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    rd_csr(v);
    chk("R6 done cleared after read then write 0", v, csr_val(3'd1, 1'b0, 1'b1, 1'b0, 1'b0));
    chk("R5 irq low after clear", {9'b0, irq}, 10'h000);

    // R4 aliasing: channel 5 into the second register
    convert(3'd5, 1'b1, 10'h155);
    sb_read_all("R4 channel 5 aliases channel 1");

    // R6 write 0 without prior read keeps done; write 1 cannot set
    csr_write(3'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    rd_csr(v);
    chk("R6 done kept without prior read", v, csr_val(3'd5, 1'b0, 1'b1, 1'b0, 1'b1));
    csr_write(3'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    csr_write(3'd5, 1'b0, 1'b1, 1'b0, 1'b1);
    rd_csr(v);
    chk("R6 write 1 does not set done", v, csr_val(3'd5, 1'b0, 1'b1, 1'b0, 1'b0));

    // R5 done with enable off
    convert(3'd2, 1'b0, 10'h0AA);
    chk("R5 irq low with enable off", {9'b0, irq}, 10'h000);
    clear_done(3'd2, 1'b1);
    rd_csr(v);
    chk("R6 cleared before abort test", v, csr_val(3'd2, 1'b0, 1'b1, 1'b0, 1'b0));

    // R7 abort
    ain = 10'h3FF;
    csr_write(3'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    csr_write(3'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 dac_code zero after abort", dac_code, 10'h000);
    repeat (15) @(negedge clk);
    rd_csr(v);
    chk("R7 no done after abort", v, csr_val(3'd2, 1'b0, 1'b1, 1'b0, 1'b0));
    sb_read_all("R7 result regs unchanged by abort");

    // R8 channel change in the starting write
    convert(3'd3, 1'b1, 10'h001);
    sb_read_all("R8 new channel used");

    // R3 extremes
    convert(3'd0, 1'b1, 10'h3FF);
    sb_read_all("R3 full scale");
    convert(3'd4, 1'b1, 10'h000);
    sb_read_all("R3 zero level channel 4");

    // R9 external trigger
    clear_done(3'd7, 1'b1);
    ain = 10'h1C3;
    ext_trig = 1'b1;
    repeat (2) @(negedge clk);
    ext_trig = 1'b0;
    repeat (16) @(negedge clk);
    rd_csr(v);
    chk("R9 trigger conversion done", v, csr_val(3'd7, 1'b0, 1'b1, 1'b0, 1'b1));
    exp_d[3] = 10'h1C3;
    sb_read_all("R9 trigger result");

    // R10 trigger while busy
    clear_done(3'd6, 1'b1);
    ain = 10'h0F0;
    csr_write(3'd6, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    ext_trig = 1'b1;
    repeat (2) @(negedge clk);
    ext_trig = 1'b0;
    repeat (8) @(negedge clk);
    ain = 10'h2FF;
    repeat (20) @(negedge clk);
    rd_csr(v);
    chk("R10 no second conversion", v, csr_val(3'd6, 1'b0, 1'b1, 1'b0, 1'b1));
    exp_d[2] = 10'h0F0;
    sb_read_all("R10 result from first conversion only");

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule